// File: doc/BRIEF.md
# Two-Channel Cascaded Biquad Equalizer

This block equalizes a stereo stream of 24-bit samples. A new sample pair arrives with a one-cycle strobe at the audio rate, about 96 kHz, which leaves hundreds of core clock cycles between pairs. Each channel's sample is first scaled by a programmable prescale gain. It then runs through four second-order IIR sections in series, applied in order 1, 2, 3, 4. Every coefficient is a signed 28-bit number with 25 fraction bits (range -4.0 to just under +4.0). A single multiply-accumulate unit is shared in time by both channels and all sections, so one sample pair takes a fixed number of clock cycles to process.

Software writes coefficients through a simple write port at any time. Each write lands in a shadow copy. The shadow set is moved into the working set only when a sample pair is accepted, so a sample is never filtered with a mix of old and new coefficients. A global bypass input sends both channels around the equalizer. A bypass input per channel does the same for one channel only. Bypassed samples come out with exactly the same latency as filtered ones, so the two channels stay aligned.

Top module: `eq_cascade`

## Requirements
- R1: After reset, out_valid is 0 and out_l/out_r are 0. Every prescale gain resets to 1.0 (raw 2^25). Each section resets to b0 = 1.0 with all other coefficients 0, so the first sample pair passes unchanged.
- R2: A coefficient write (cw_en high for one cycle) stores cw_val into the shadow set of channel cw_ch (0 = left, 1 = right). cw_idx selects the target: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2 of section cw_sect (0..3 for sections 1..4), and 5 = the channel prescale gain, in which case cw_sect is ignored. Values 6 and 7 are ignored.
- R3: The prescale stage gives s = sat(floor(p·x / 2^25)), where p is the channel's prescale gain and x is its input sample.
- R4: Each section computes y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 in direct form I. The sum is arithmetic-shifted right by 25 (floor). Sections run in order 1..4, each with its own history per channel.
- R5: The prescale result and every section result are saturated to the 24-bit range [-8388608, 8388607].
- R6: A write takes effect at the next accepted sample strobe. A write made in the same cycle as an accepted strobe is not used for that sample pair, only from the following one.
- R7: While bypass_ch[c] is 1 at the accepting strobe, channel c outputs its input sample unchanged and its section histories are left untouched. The other channel is unaffected.
- R8: While bypass_all is 1 at the accepting strobe, both channels output their input samples unchanged and no history is updated.
- R9: out_valid is a one-cycle pulse exactly 43 clock cycles after the edge that accepts a strobe, with or without bypass. out_l/out_r change only together with out_valid.
- R10: A strobe that arrives while a sample pair is still being processed is ignored. It produces no output and does not change the result of the pair in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| bypass_all | input | 1 | Bypass both channels |
| bypass_ch | input | 2 | Bypass per channel, bit 0 left, bit 1 right |
| cw_en | input | 1 | Coefficient write enable |
| cw_ch | input | 1 | Channel of the coefficient write |
| cw_sect | input | 2 | Section of the coefficient write |
| cw_idx | input | 3 | Coefficient selector of the write |
| cw_val | input | 28 | Coefficient value, signed Q3.25 |
| out_valid | output | 1 | Output pair strobe |
| out_l | output | 24 | Left output sample, signed |
| out_r | output | 24 | Right output sample, signed |

## Verification
A wrong sequencer count shifts the out_valid pulse away from cycle 43 on the very first sample pair. A wrong operand or coefficient selection corrupts the first output as soon as a non-identity coefficient is loaded. Faults in history handling, such as a missing shift or an update during bypass, only show on the second and later samples through a filtered section. For that reason the bench runs multi-sample sequences against a sample-accurate model and resumes filtering right after each bypass episode. Faults in coefficient commit timing show on the pair right after a write, and saturation faults show on a single full-scale sample.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int EQ_DATA_W    = 24;
  localparam int EQ_COEF_W    = 28;
  localparam int EQ_COEF_FRAC = 25;
  localparam int EQ_ACC_W     = 56;
  localparam int EQ_N_SECT    = 4;
  localparam int EQ_N_CH      = 2;
  localparam int EQ_N_TERM    = 5;

  // selector of a coefficient inside a section, plus the prescale gain
  typedef enum logic [2:0] {
    TAP_B0  = 3'd0,
    TAP_B1  = 3'd1,
    TAP_B2  = 3'd2,
    TAP_A1  = 3'd3,
    TAP_A2  = 3'd4,
    TAP_PRE = 3'd5
  } tap_e;
endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank
  import eq_pkg::*;
#(
  parameter  int N_CH      = EQ_N_CH,
  parameter  int N_SECT    = EQ_N_SECT,
  parameter  int N_TERM    = EQ_N_TERM,
  parameter  int COEF_W    = EQ_COEF_W,
  parameter  int COEF_FRAC = EQ_COEF_FRAC,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SECT_W    = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int TM_W      = $clog2(N_TERM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [SECT_W-1:0]        wr_sect,
  input  logic [2:0]               wr_idx,
  input  logic [COEF_W-1:0]        wr_val,
  input  logic                     commit,
  input  logic [CH_W-1:0]          rd_ch,
  input  logic                     rd_pre,
  input  logic [SECT_W-1:0]        rd_sect,
  input  logic [TM_W-1:0]          rd_tm,
  output logic signed [COEF_W-1:0] rd_coef
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << COEF_FRAC;

  logic signed [COEF_W-1:0] act_pre [N_CH];
  logic signed [COEF_W-1:0] act_tap [N_CH][N_SECT][N_TERM];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [COEF_W-1:0] pre_sh_q, pre_act_q;
    logic              pre_wr;

    assign pre_wr = wr_en && (wr_ch == CH_W'(c)) && (wr_idx == TAP_PRE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_sh_q <= UNITY;
      else if (pre_wr) pre_sh_q <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_act_q <= UNITY;
      else if (commit) pre_act_q <= pre_sh_q;
    end

    assign act_pre[c] = pre_act_q;

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      for (genvar t = 0; t < N_TERM; t++) begin : g_tap
        localparam logic [COEF_W-1:0] RST_VAL = (t == 0) ? UNITY : '0;
        logic [COEF_W-1:0] sh_q, act_q;
        logic              tap_wr;

        assign tap_wr = wr_en && (wr_ch == CH_W'(c)) &&
                        (wr_sect == SECT_W'(s)) && (wr_idx == 3'(t));

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      sh_q <= RST_VAL;
          else if (tap_wr) sh_q <= wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      act_q <= RST_VAL;
          else if (commit) act_q <= sh_q;
        end

        assign act_tap[c][s][t] = act_q;
      end
    end
  end

  assign rd_coef = rd_pre ? act_pre[rd_ch] : act_tap[rd_ch][rd_sect][rd_tm];
endmodule

// File: rtl/eq_mac.sv
module eq_mac
  import eq_pkg::*;
#(
  parameter  int DATA_W    = EQ_DATA_W,
  parameter  int COEF_W    = EQ_COEF_W,
  parameter  int COEF_FRAC = EQ_COEF_FRAC,
  parameter  int ACC_W     = EQ_ACC_W,
  localparam int PROD_W    = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic                     sub,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [DATA_W-1:0] opnd,
  output logic signed [DATA_W-1:0] res
);
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SMIN = -SMAX - ACC_W'(1);

  logic signed [PROD_W-1:0] prod_full;
  logic signed [ACC_W-1:0]  prod, acc_q, acc_d, shifted;

  assign prod_full = coef * opnd;
  assign prod      = ACC_W'(prod_full);

  always_comb begin
    acc_d   = (clr ? '0 : acc_q) + (sub ? -prod : prod);
    shifted = acc_d >>> COEF_FRAC;
    if (shifted > SMAX)      res = SMAX[DATA_W-1:0];
    else if (shifted < SMIN) res = SMIN[DATA_W-1:0];
    else                     res = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/eq_seq.sv
module eq_seq
  import eq_pkg::*;
#(
  parameter  int N_CH   = EQ_N_CH,
  parameter  int N_SECT = EQ_N_SECT,
  parameter  int N_TERM = EQ_N_TERM,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int TM_W   = $clog2(N_TERM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [CH_W-1:0]   ch,
  output logic              is_pre,
  output logic [SECT_W-1:0] sect,
  output logic [TM_W-1:0]   tm,
  output logic              term_last,
  output logic              ch_last,
  output logic              all_last
);
  localparam logic [TM_W-1:0]   TM_LAST   = TM_W'(N_TERM - 1);
  localparam logic [SECT_W-1:0] SECT_LAST = SECT_W'(N_SECT - 1);
  localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(N_CH - 1);

  logic              busy_q, busy_d, pre_q, pre_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [TM_W-1:0]   tm_q, tm_d;

  always_comb begin
    busy_d = busy_q;
    pre_d  = pre_q;
    ch_d   = ch_q;
    sect_d = sect_q;
    tm_d   = tm_q;
    if (start) begin
      busy_d = 1'b1;
      pre_d  = 1'b1;
      ch_d   = '0;
      sect_d = '0;
      tm_d   = '0;
    end else if (busy_q) begin
      if (pre_q) begin
        pre_d = 1'b0;
        tm_d  = '0;
      end else if (tm_q == TM_LAST) begin
        tm_d = '0;
        if (sect_q == SECT_LAST) begin
          sect_d = '0;
          if (ch_q == CH_LAST) begin
            busy_d = 1'b0;
          end else begin
            ch_d  = ch_q + CH_W'(1);
            pre_d = 1'b1;
          end
        end else begin
          sect_d = sect_q + SECT_W'(1);
        end
      end else begin
        tm_d = tm_q + TM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      ch_q   <= '0;
      sect_q <= '0;
      tm_q   <= '0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      ch_q   <= ch_d;
      sect_q <= sect_d;
      tm_q   <= tm_d;
    end
  end

  assign busy      = busy_q;
  assign ch        = ch_q;
  assign is_pre    = pre_q;
  assign sect      = sect_q;
  assign tm        = tm_q;
  assign term_last = pre_q || (tm_q == TM_LAST);
  assign ch_last   = !pre_q && (tm_q == TM_LAST) && (sect_q == SECT_LAST);
  assign all_last  = ch_last && (ch_q == CH_LAST);
endmodule

// File: rtl/eq_cascade.sv
module eq_cascade
  import eq_pkg::*;
#(
  parameter  int DATA_W    = EQ_DATA_W,
  parameter  int COEF_W    = EQ_COEF_W,
  parameter  int COEF_FRAC = EQ_COEF_FRAC,
  parameter  int ACC_W     = EQ_ACC_W,
  parameter  int N_SECT    = EQ_N_SECT,
  localparam int N_CH      = 2,
  localparam int CH_W      = 1,
  localparam int SECT_W    = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int N_TERM    = EQ_N_TERM,
  localparam int TM_W      = $clog2(N_TERM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_l,
  input  logic signed [DATA_W-1:0] in_r,
  input  logic                     bypass_all,
  input  logic [N_CH-1:0]          bypass_ch,
  input  logic                     cw_en,
  input  logic [CH_W-1:0]          cw_ch,
  input  logic [SECT_W-1:0]        cw_sect,
  input  logic [2:0]               cw_idx,
  input  logic [COEF_W-1:0]        cw_val,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_l,
  output logic signed [DATA_W-1:0] out_r
);
  logic              busy, accept, is_pre, term_last, ch_last, all_last, stage_done;
  logic [CH_W-1:0]   ch;
  logic [SECT_W-1:0] sect;
  logic [TM_W-1:0]   tm;

  logic signed [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] opnd, mac_res;
  logic                     mac_clr, mac_sub;

  logic signed [DATA_W-1:0] smp_in [N_CH];
  logic signed [DATA_W-1:0] cap    [N_CH];
  logic signed [DATA_W-1:0] res    [N_CH];
  logic [N_CH-1:0]          byp;
  logic signed [DATA_W-1:0] hx1 [N_CH][N_SECT];
  logic signed [DATA_W-1:0] hx2 [N_CH][N_SECT];
  logic signed [DATA_W-1:0] hy1 [N_CH][N_SECT];
  logic signed [DATA_W-1:0] hy2 [N_CH][N_SECT];

  logic signed [DATA_W-1:0] cur_q;
  logic                     fin_q, vld_q;
  logic signed [DATA_W-1:0] ol_q, or_q;

  assign accept     = in_valid && !busy;
  assign stage_done = busy && term_last;
  assign smp_in[0]  = in_l;
  assign smp_in[1]  = in_r;

  eq_seq #(.N_CH(N_CH), .N_SECT(N_SECT), .N_TERM(N_TERM)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .ch(ch),
    .is_pre(is_pre), .sect(sect), .tm(tm), .term_last(term_last),
    .ch_last(ch_last), .all_last(all_last)
  );

  eq_coef_bank #(.N_CH(N_CH), .N_SECT(N_SECT), .N_TERM(N_TERM),
                 .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_ch(cw_ch), .wr_sect(cw_sect),
    .wr_idx(cw_idx), .wr_val(cw_val), .commit(accept), .rd_ch(ch),
    .rd_pre(is_pre), .rd_sect(sect), .rd_tm(tm), .rd_coef(coef)
  );

  always_comb begin
    if (is_pre) begin
      opnd = cap[ch];
    end else begin
      case (tm)
        TAP_B1:  opnd = hx1[ch][sect];
        TAP_B2:  opnd = hx2[ch][sect];
        TAP_A1:  opnd = hy1[ch][sect];
        TAP_A2:  opnd = hy2[ch][sect];
        default: opnd = cur_q;
      endcase
    end
    mac_clr = is_pre || (tm == TAP_B0);
    mac_sub = !is_pre && ((tm == TAP_A1) || (tm == TAP_A2));
  end

  eq_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
           .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(busy), .clr(mac_clr), .sub(mac_sub),
    .coef(coef), .opnd(opnd), .res(mac_res)
  );

  // current stage input: prescale result, then each section result in turn
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur_q <= '0;
    else if (stage_done) cur_q <= mac_res;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [DATA_W-1:0] cap_q, res_q;
    logic                     byp_q, res_en;

    assign res_en = stage_done && ch_last && (ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q <= '0;
        byp_q <= 1'b0;
      end else if (accept) begin
        cap_q <= smp_in[c];
        byp_q <= bypass_all || bypass_ch[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (res_en) res_q <= byp_q ? cap_q : mac_res;
    end

    assign cap[c] = cap_q;
    assign byp[c] = byp_q;
    assign res[c] = res_q;

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      logic signed [DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;
      logic                     upd;

      assign upd = stage_done && !is_pre && !byp_q &&
                   (ch == CH_W'(c)) && (sect == SECT_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          x1_q <= '0;
          x2_q <= '0;
          y1_q <= '0;
          y2_q <= '0;
        end else if (upd) begin
          x2_q <= x1_q;
          x1_q <= cur_q;
          y2_q <= y1_q;
          y1_q <= mac_res;
        end
      end

      assign hx1[c][s] = x1_q;
      assign hx2[c][s] = x2_q;
      assign hy1[c][s] = y1_q;
      assign hy2[c][s] = y2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= busy && all_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ol_q  <= '0;
      or_q  <= '0;
    end else begin
      vld_q <= fin_q;
      if (fin_q) begin
        ol_q <= res[0];
        or_q <= res[1];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_l     = ol_q;
  assign out_r     = or_q;
endmodule

// File: rtl/eq_cascade_chk.sv
module eq_cascade_chk #(
  parameter  int DATA_W = 24,
  parameter  int N_SECT = 4,
  localparam int LAT    = 2 * (1 + 5 * N_SECT) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_l,
  input logic [DATA_W-1:0] in_r,
  input logic              bypass_all,
  input logic [1:0]        bypass_ch,
  input logic              busy,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r
);
  logic              acc_ev, pend;
  logic [7:0]        cnt;
  logic [DATA_W-1:0] cap_l, cap_r;
  logic              cap_all;
  logic [1:0]        cap_byp;

  assign acc_ev = in_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      cnt     <= '0;
      cap_l   <= '0;
      cap_r   <= '0;
      cap_all <= 1'b0;
      cap_byp <= '0;
    end else begin
      if (acc_ev) begin
        pend    <= 1'b1;
        cnt     <= '0;
        cap_l   <= in_l;
        cap_r   <= in_r;
        cap_all <= bypass_all;
        cap_byp <= bypass_ch | {2{bypass_all}};
      end else begin
        if (pend && cnt != 8'hFF) cnt <= cnt + 8'd1;
        if (out_valid)            pend <= 1'b0;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend && cnt == 8'(LAT))); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_l) && $stable(out_r))); // R9
  AST_GLOBAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_all) |-> (out_l == cap_l && out_r == cap_r)); // R8
  AST_LEFT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_byp[0]) |-> (out_l == cap_l)); // R7
  AST_RIGHT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_byp[1]) |-> (out_r == cap_r)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> busy); // R10
endmodule

bind eq_cascade eq_cascade_chk #(.DATA_W(DATA_W), .N_SECT(N_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
  .bypass_all(bypass_all), .bypass_ch(bypass_ch), .busy(busy),
  .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
);

// File: tb/eq_cascade_bench.sv
module eq_cascade_bench;
  localparam longint ONE  = 64'sd1 <<< 25;
  localparam longint SMAX = 64'sd8388607;
  localparam longint SMIN = -64'sd8388608;
  localparam int     LAT  = 43;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, bypass_all, cw_en;
  logic signed [23:0] in_l, in_r;
  logic [1:0]         bypass_ch, cw_sect;
  logic [0:0]         cw_ch;
  logic [2:0]         cw_idx;
  logic [27:0]        cw_val;
  logic               out_valid;
  logic signed [23:0] out_l, out_r;

  int checks = 0;
  int errors = 0;

  longint psh [2], pact [2];
  longint bsh [2][4][5], bact [2][4][5];
  longint mx1 [2][4], mx2 [2][4], my1 [2][4], my2 [2][4];

  always #5 clk = ~clk;

  eq_cascade u_eq_cascade (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .bypass_all(bypass_all), .bypass_ch(bypass_ch), .cw_en(cw_en),
    .cw_ch(cw_ch), .cw_sect(cw_sect), .cw_idx(cw_idx), .cw_val(cw_val),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic model(input int c, input longint x, input bit byp, output longint y);
    longint s, acc, r;
    s = sat((pact[c] * x) >>> 25);
    for (int k = 0; k < 4; k++) begin
      acc = bact[c][k][0] * s + bact[c][k][1] * mx1[c][k] + bact[c][k][2] * mx2[c][k]
          - bact[c][k][3] * my1[c][k] - bact[c][k][4] * my2[c][k];
      r = sat(acc >>> 25);
      if (!byp) begin
        mx2[c][k] = mx1[c][k];
        mx1[c][k] = s;
        my2[c][k] = my1[c][k];
        my1[c][k] = r;
      end
      s = r;
    end
    y = byp ? x : s;
  endtask

  task automatic model_write(input int c, input int s, input int idx, input longint v);
    if (idx == 5) psh[c] = v;
    else if (idx < 5) bsh[c][s][idx] = v;
  endtask

  task automatic wr_coef(input int c, input int s, input int idx, input longint v);
    @(negedge clk);
    cw_en = 1'b1; cw_ch = 1'(c); cw_sect = 2'(s); cw_idx = 3'(idx); cw_val = 28'(v);
    @(negedge clk);
    cw_en = 1'b0;
    model_write(c, s, idx, v);
  endtask

  // one sample pair; optional same-cycle coefficient write and mid-run strobe
  task automatic strobe(input longint l, input longint r, input bit ba, input bit [1:0] bc,
                        input bit wr, input int wc, input int ws, input int wi, input longint wv,
                        input bit poke, output longint gl, output longint gr, output int k);
    pact = psh;
    bact = bsh;
    @(negedge clk);
    in_l = 24'(l); in_r = 24'(r); bypass_all = ba; bypass_ch = bc; in_valid = 1'b1;
    if (wr) begin
      cw_en = 1'b1; cw_ch = 1'(wc); cw_sect = 2'(ws); cw_idx = 3'(wi); cw_val = 28'(wv);
    end
    @(negedge clk);
    in_valid = 1'b0; cw_en = 1'b0;
    if (wr) model_write(wc, ws, wi, wv);
    k = 0;
    while (!out_valid && k < 100) begin
      @(negedge clk);
      k++;
      if (poke && k == 10) begin
        in_l = 24'(l + 1111); in_r = 24'(r - 2222); in_valid = 1'b1;
      end
      if (poke && k == 11) in_valid = 1'b0;
    end
    gl = longint'(out_l);
    gr = longint'(out_r);
  endtask

  task automatic go(input longint l, input longint r, input bit ba, input bit [1:0] bc,
                    input string tag, output longint gl, output longint gr);
    longint el, er;
    int k;
    strobe(l, r, ba, bc, 1'b0, 0, 0, 0, 0, 1'b0, gl, gr, k);
    model(0, l, ba | bc[0], el);
    model(1, r, ba | bc[1], er);
    chk(k == LAT, {tag, " R9 latency"}, k, LAT);
    chk(gl == el, {tag, " left"}, gl, el);
    chk(gr == er, {tag, " right"}, gr, er);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_l = '0; in_r = '0; bypass_all = 1'b0;
    bypass_ch = '0; cw_en = 1'b0; cw_ch = '0; cw_sect = '0; cw_idx = '0; cw_val = '0;
    for (int c = 0; c < 2; c++) begin
      psh[c] = ONE;
      for (int s = 0; s < 4; s++) begin
        mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
        for (int t = 0; t < 5; t++) bsh[c][s][t] = (t == 0) ? ONE : 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(out_l == 0 && out_r == 0, "R1 outputs after reset", longint'(out_l), 0);
  endtask

  task automatic t_identity;
    longint gl, gr;
    go(1000, -2000, 1'b0, 2'b00, "R1 identity", gl, gr);
    chk(gl == 1000 && gr == -2000, "R1 unity passthrough", gl, 1000);
    go(-8388608, 8388607, 1'b0, 2'b00, "R1 full scale", gl, gr);
  endtask

  task automatic t_saturate;
    longint gl, gr;
    wr_coef(0, 0, 5, 3 * ONE);
    wr_coef(1, 0, 5, 3 * ONE);
    go(8000000, -8000000, 1'b0, 2'b00, "R5 saturate", gl, gr);
    chk(gl == SMAX, "R5 positive clip", gl, SMAX);
    chk(gr == SMIN, "R5 negative clip", gr, SMIN);
    wr_coef(0, 0, 5, ONE);
    wr_coef(1, 0, 5, ONE);
  endtask

  task automatic t_commit;
    longint gl, gr, el, er;
    int k;
    strobe(40000, 50001, 1'b0, 2'b00, 1'b1, 1, 0, 5, ONE / 2, 1'b0, gl, gr, k);
    model(0, 40000, 1'b0, el);
    model(1, 50001, 1'b0, er);
    chk(gr == 50001, "R6 same-cycle write not used yet", gr, 50001);
    chk(gl == el && gr == er, "R6 model match", gr, er);
    go(40000, 50001, 1'b0, 2'b00, "R6 next strobe", gl, gr);
    chk(gr == 25000, "R6 write applied at next strobe", gr, 25000);
    wr_coef(1, 0, 7, 5 * ONE);
    go(40000, 50001, 1'b0, 2'b00, "R2 unused selector", gl, gr);
    chk(gr == 25000, "R2 selector 7 ignored", gr, 25000);
  endtask

  task automatic t_prescale;
    longint gl, gr;
    wr_coef(0, 3, 5, ONE / 2);
    wr_coef(1, 1, 5, -ONE);
    go(-12345, 777, 1'b0, 2'b00, "R3 prescale", gl, gr);
    chk(gl == -6173, "R3 half gain floors", gl, -6173);
    chk(gr == -777, "R3 negative unity gain", gr, -777);
    wr_coef(0, 0, 5, ONE);
    wr_coef(1, 0, 5, ONE);
  endtask

  task automatic t_cascade;
    longint gl, gr;
    longint xs [6] = '{100000, 2000000, -4000000, 7, 8000000, 0};
    longint ys [6] = '{-50000, 3000000, 123, -7, -8000000, 0};
    wr_coef(0, 0, 0, ONE / 2);
    wr_coef(0, 0, 1, ONE / 4);
    wr_coef(0, 0, 3, -ONE / 2);
    wr_coef(0, 2, 2, -ONE / 4);
    wr_coef(1, 3, 0, 3 * ONE / 2);
    wr_coef(1, 3, 4, ONE / 4);
    wr_coef(1, 1, 3, ONE / 8);
    for (int i = 0; i < 6; i++) go(xs[i], ys[i], 1'b0, 2'b00, "R4 cascade", gl, gr);
  endtask

  task automatic t_bypass;
    longint gl, gr;
    go(300000, -400000, 1'b0, 2'b10, "R7 right bypass", gl, gr);
    chk(gr == -400000, "R7 right raw", gr, -400000);
    go(-300000, 400000, 1'b0, 2'b01, "R7 left bypass", gl, gr);
    chk(gl == -300000, "R7 left raw", gl, -300000);
    go(250000, 250000, 1'b0, 2'b00, "R7 history resumes", gl, gr);
    go(654321, -654321, 1'b1, 2'b00, "R8 global bypass", gl, gr);
    chk(gl == 654321 && gr == -654321, "R8 both raw", gl, 654321);
    go(111111, -222222, 1'b0, 2'b00, "R8 history resumes", gl, gr);
  endtask

  task automatic t_busy;
    longint gl, gr, el, er;
    int k, extra;
    strobe(500000, -600000, 1'b0, 2'b00, 1'b0, 0, 0, 0, 0, 1'b1, gl, gr, k);
    model(0, 500000, 1'b0, el);
    model(1, -600000, 1'b0, er);
    chk(k == LAT, "R10 latency unchanged", k, LAT);
    chk(gl == el && gr == er, "R10 in-flight result", gl, el);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    chk(extra == 0, "R10 no output for ignored strobe", extra, 0);
    go(77, -77, 1'b0, 2'b00, "R10 after ignored strobe", gl, gr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_identity();
    t_saturate();
    t_commit();
    t_prescale();
    t_cascade();
    t_bypass();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule